// File: doc/BRIEF.md
# Two-Channel Codec Serial Control Port

This block is the write-only configuration port of a two-channel speech codec. A host drives a serial clock, a serial data line and an active-low select. Each access is a 16-bit transfer that is shifted in least significant bit first. The first byte is a command: a device address that must equal six strap inputs, a channel-select bit and a spare bit. The second byte is the control byte, and it is written into the chosen channel's register.

All serial inputs are brought into the system clock domain through synchronizers, and their edges are detected there. Each channel's register drives the codec directly. It provides an idle flag, an algorithm-reset request, a bypass flag, a data-format flag and a two-bit coding-rate code. It also holds a side-disable bit that turns off that side's PCM output enable. When both sides are disabled, the block raises a standby flag. The algorithm-reset request stays high until the processing engine reports that the reset has finished, and the block then clears it.

Top module: `ser_ctrl_port`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every control field of both channels is cleared. After that edge `side_oe` is 2'b11 and `standby` is 0.
- R2: `ser_din` is sampled on each rising edge of `ser_clk` while `ser_cs_n` is low, least significant bit first. Transfer bits 0-5 are the address (bit 0 is the LSB), bit 6 selects the channel (0 or 1), bit 7 is spare, and bits 8-15 are the control byte. The write takes effect after the 16th bit.
- R3: The control byte is laid out as follows: bit 0 idle, bit 1 algorithm reset, bit 2 bypass, bit 3 data format, bits 5:4 coding rate, bit 6 side disable. Bit 7 is ignored.
- R4: If any of transfer bits 0-5 differs from `addr_strap`, neither channel's register changes.
- R5: If `ser_cs_n` rises before the 16th bit, nothing is written, and the next transfer starts again at bit 0.
- R6: Bits after the 16th within the same low period of `ser_cs_n` are ignored.
- R7: Writing a control byte with bit 1 set raises `chan_alg_rst` for that channel. The flag stays high until `alg_done` for that channel is high, and it is low one cycle later. Writing bit 1 as 0 does not clear it.
- R8: `side_oe[i]` is low exactly while channel i's side-disable bit is set.
- R9: `standby` is high one cycle after both side-disable bits are set, and low one cycle after either one is cleared.
- R10: A write to one channel leaves the other channel's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 6 | Strapped device address |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data, LSB first |
| ser_cs_n | input | 1 | Active-low serial select |
| alg_done | input | 2 | Per-channel algorithm reset completion from the engine |
| chan_idle | output | 2 | Idle flag per channel |
| chan_alg_rst | output | 2 | Algorithm reset request per channel |
| chan_bypass | output | 2 | Bypass flag per channel |
| chan_fmt | output | 2 | Data format flag per channel |
| chan_rate | output | 4 | Coding rate, 2 bits per channel (channel 1 in [3:2]) |
| side_oe | output | 2 | PCM output enable per side |
| standby | output | 1 | Both sides disabled |

## Verification
The hardest states to reach are those where the serial sequence goes wrong: a transfer cut off partway, extra bits sent after a complete word, and an address that matches except in its top bit. The bench produces each of these with a bit-level serial task that takes the number of clock edges to send. It then checks the outputs, and in the abort case it follows up with a clean write to show that the bit counter was reset. The algorithm-reset tests send a completion pulse from `alg_done` only after confirming that the flag is still being held. They also rewrite the same channel with bit 1 cleared while the flag is set.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int ADDR_W   = 6;
  localparam int CMD_BITS = 8;
  localparam int DATA_W   = 8;
  localparam int FRAME    = CMD_BITS + DATA_W;
  localparam int CNT_W    = $clog2(FRAME + 1);
  localparam int CFG_W    = 7;

  typedef struct packed {
    logic       side_dis;
    logic [1:0] rate;
    logic       fmt;
    logic       bypass;
    logic       alg_rst;
    logic       idle;
  } chan_ctrl_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[b]}};
      else     pipe <= {pipe[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_ctrl_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  input  logic [ADDR_W-1:0] strap,
  output logic              wr_stb,
  output logic [$clog2(NCH)-1:0] wr_ch,
  output logic [CFG_W-1:0]  wr_data
);
  localparam int CH_POS    = ADDR_W;
  localparam int DATA_BASE = CMD_BITS;

  logic             sclk_d;
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic             reject;
  logic             ch_q;
  logic [CFG_W-1:0] data_q;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      reject  <= 1'b0;
      ch_q    <= 1'b0;
      data_q  <= '0;
      wr_stb  <= 1'b0;
      wr_ch   <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (csn_s) begin
        cnt    <= '0;
        reject <= 1'b0;
      end else if (rise && cnt != CNT_W'(FRAME)) begin
        cnt <= cnt + 1'b1;
        for (int b = 0; b < ADDR_W; b++)
          if (cnt == CNT_W'(b) && sdi_s != strap[b]) reject <= 1'b1;
        if (cnt == CNT_W'(CH_POS)) ch_q <= sdi_s;
        for (int b = 0; b < CFG_W; b++)
          if (cnt == CNT_W'(DATA_BASE + b)) data_q[b] <= sdi_s;
        if (cnt == CNT_W'(FRAME - 1)) begin
          wr_stb  <= ~reject;
          wr_ch   <= $clog2(NCH)'(ch_q);
          wr_data <= data_q;
        end
      end
    end
  end
endmodule

// File: rtl/chan_reg.sv
module chan_reg
  import ser_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             done,
  output chan_ctrl_t       ctrl,
  output logic             oe
);
  chan_ctrl_t nd;
  assign nd = chan_ctrl_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      oe   <= 1'b1;
    end else begin
      if (wr_en) begin
        ctrl.idle     <= nd.idle;
        ctrl.bypass   <= nd.bypass;
        ctrl.fmt      <= nd.fmt;
        ctrl.rate     <= nd.rate;
        ctrl.side_dis <= nd.side_dis;
        oe            <= ~nd.side_dis;
      end
      if (wr_en && nd.alg_rst) ctrl.alg_rst <= 1'b1;
      else if (done)           ctrl.alg_rst <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port
  import ser_ctrl_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_cs_n,
  input  logic [NCH-1:0]    alg_done,
  output logic [NCH-1:0]    chan_idle,
  output logic [NCH-1:0]    chan_alg_rst,
  output logic [NCH-1:0]    chan_bypass,
  output logic [NCH-1:0]    chan_fmt,
  output logic [2*NCH-1:0]  chan_rate,
  output logic [NCH-1:0]    side_oe,
  output logic              standby
);
  localparam int CH_W = $clog2(NCH);

  logic [2:0]       sync_out;
  logic             wr_stb;
  logic [CH_W-1:0]  wr_ch;
  logic [CFG_W-1:0] wr_data;
  chan_ctrl_t       ctrl [NCH];
  logic [NCH-1:0]   dis;

  ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({ser_cs_n, ser_din, ser_clk}),
    .d_out(sync_out)
  );

  ser_frame_rx #(.NCH(NCH)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sync_out[0]),
    .sdi_s  (sync_out[1]),
    .csn_s  (sync_out[2]),
    .strap  (addr_strap),
    .wr_stb (wr_stb),
    .wr_ch  (wr_ch),
    .wr_data(wr_data)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_reg u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_stb && wr_ch == CH_W'(i)),
      .wr_data(wr_data),
      .done   (alg_done[i]),
      .ctrl   (ctrl[i]),
      .oe     (side_oe[i])
    );
    assign chan_idle[i]        = ctrl[i].idle;
    assign chan_alg_rst[i]     = ctrl[i].alg_rst;
    assign chan_bypass[i]      = ctrl[i].bypass;
    assign chan_fmt[i]         = ctrl[i].fmt;
    assign chan_rate[2*i +: 2] = ctrl[i].rate;
    assign dis[i]              = ctrl[i].side_dis;
  end

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b0;
    else     standby <= &dis;
  end
endmodule

// File: rtl/ser_ctrl_chk.sv
module ser_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic [NCH-1:0]   alg_done,
  input logic [NCH-1:0]   chan_idle,
  input logic [NCH-1:0]   chan_alg_rst,
  input logic [NCH-1:0]   chan_bypass,
  input logic [NCH-1:0]   chan_fmt,
  input logic [2*NCH-1:0] chan_rate,
  input logic [NCH-1:0]   side_oe,
  input logic             standby
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (chan_idle == '0 && chan_alg_rst == '0 && chan_bypass == '0 &&
             chan_fmt == '0 && chan_rate == '0 && side_oe == '1 && !standby));

  // R9
  standby_on_chk: assert property (@(posedge clk) disable iff (rst)
    (side_oe == '0) |=> standby);

  // R9
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    (side_oe != '0) |=> !standby);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_stb) && !$past(rst)) |->
      ($stable(chan_idle) && $stable(chan_bypass) && $stable(chan_fmt) &&
       $stable(chan_rate) && $stable(side_oe)));

  for (genvar i = 0; i < NCH; i++) begin : g_alg
    // R7
    alg_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(chan_alg_rst[i]) |-> ($past(alg_done[i]) || $past(rst)));
    // R7
    alg_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(chan_alg_rst[i]) |-> $past(wr_stb));
  end
endmodule

bind ser_ctrl_port ser_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_stb      (wr_stb),
  .alg_done    (alg_done),
  .chan_idle   (chan_idle),
  .chan_alg_rst(chan_alg_rst),
  .chan_bypass (chan_bypass),
  .chan_fmt    (chan_fmt),
  .chan_rate   (chan_rate),
  .side_oe     (side_oe),
  .standby     (standby)
);

// File: tb/sim_ser_ctrl_port.sv
`timescale 1ns/1ps
module sim_ser_ctrl_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] addr_strap = 6'h2D;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       ser_cs_n = 1'b1;
  logic [1:0] alg_done = 2'b00;
  logic [1:0] chan_idle, chan_alg_rst, chan_bypass, chan_fmt, side_oe;
  logic [3:0] chan_rate;
  logic       standby;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ser_ctrl_port u0 (
    .clk(clk), .rst(rst), .addr_strap(addr_strap), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_cs_n(ser_cs_n), .alg_done(alg_done),
    .chan_idle(chan_idle), .chan_alg_rst(chan_alg_rst), .chan_bypass(chan_bypass),
    .chan_fmt(chan_fmt), .chan_rate(chan_rate), .side_oe(side_oe), .standby(standby)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [5:0] a, input logic ch, input logic [7:0] d);
    return {d, 1'b0, ch, a};
  endfunction

  function automatic logic [31:0] snap();
    return {9'd0, standby, side_oe, chan_rate, chan_fmt, chan_bypass, chan_alg_rst, chan_idle};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n, input logic [7:0] extra, input int nx);
    ser_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n + nx; i++) begin
      ser_din = (i < n) ? w[i] : extra[i-n];
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    ser_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 idle", chan_idle, 2'b00);
    chk("R1 alg", chan_alg_rst, 2'b00);
    chk("R1 rate", chan_rate, 4'h0);
    chk("R1 oe", side_oe, 2'b11);
    chk("R1 standby", standby, 1'b0);
  endtask

  task automatic t_fields();
    do_reset();
    send(word(6'h2D, 1'b0, 8'b1011_1101), 16, 8'h00, 0);
    // R2 R3: idle=1 alg=0 bypass=1 fmt=1 rate=3 dis=0, spare bit7 ignored
    chk("R3 idle", chan_idle, 2'b01);
    chk("R3 bypass", chan_bypass, 2'b01);
    chk("R3 fmt", chan_fmt, 2'b01);
    chk("R3 rate", chan_rate, 4'b0011);
    chk("R2 alg", chan_alg_rst, 2'b00);
    send(word(6'h2D, 1'b1, 8'b0010_0100), 16, 8'h00, 0);
    // R10 channel 0 unchanged, channel 1 bypass=1 rate=2
    chk("R10 bypass", chan_bypass, 2'b11);
    chk("R10 idle", chan_idle, 2'b01);
    chk("R10 rate", chan_rate, 4'b1011);
  endtask

  task automatic t_addr();
    do_reset();
    send(word(6'h0D, 1'b0, 8'h0F), 16, 8'h00, 0);
    chk("R4 msb mismatch", snap(), {9'd0, 1'b0, 2'b11, 4'h0, 8'h00});
    send(word(6'h2C, 1'b1, 8'h0F), 16, 8'h00, 0);
    chk("R4 lsb mismatch", snap(), {9'd0, 1'b0, 2'b11, 4'h0, 8'h00});
  endtask

  task automatic t_abort();
    do_reset();
    send(word(6'h2D, 1'b0, 8'h01), 10, 8'h00, 0);
    chk("R5 abort no write", chan_idle, 2'b00);
    send(word(6'h2D, 1'b0, 8'h05), 16, 8'h00, 0);
    chk("R5 restart idle", chan_idle, 2'b01);
    chk("R5 restart bypass", chan_bypass, 2'b01);
  endtask

  task automatic t_extra();
    do_reset();
    send(word(6'h2D, 1'b1, 8'h08), 16, 8'hFF, 8);
    chk("R6 fmt", chan_fmt, 2'b10);
    chk("R6 idle untouched", chan_idle, 2'b00);
    chk("R6 oe", side_oe, 2'b11);
  endtask

  task automatic t_alg();
    do_reset();
    send(word(6'h2D, 1'b0, 8'h02), 16, 8'h00, 0);
    send(word(6'h2D, 1'b1, 8'h02), 16, 8'h00, 0);
    chk("R7 set", chan_alg_rst, 2'b11);
    repeat (20) @(negedge clk);
    chk("R7 held", chan_alg_rst, 2'b11);
    alg_done = 2'b01;
    @(negedge clk);
    alg_done = 2'b00;
    chk("R7 cleared ch0", chan_alg_rst, 2'b10);
    send(word(6'h2D, 1'b1, 8'h01), 16, 8'h00, 0);
    chk("R7 zero write keeps", chan_alg_rst, 2'b10);
    chk("R7 idle written", chan_idle, 2'b10);
    alg_done = 2'b10;
    @(negedge clk);
    alg_done = 2'b00;
    chk("R7 cleared ch1", chan_alg_rst, 2'b00);
  endtask

  task automatic t_standby();
    do_reset();
    send(word(6'h2D, 1'b0, 8'h40), 16, 8'h00, 0);
    chk("R8 oe ch0 off", side_oe, 2'b10);
    chk("R9 one side", standby, 1'b0);
    send(word(6'h2D, 1'b1, 8'h40), 16, 8'h00, 0);
    chk("R8 both off", side_oe, 2'b00);
    chk("R9 standby on", standby, 1'b1);
    send(word(6'h2D, 1'b0, 8'h00), 16, 8'h00, 0);
    chk("R8 ch0 back", side_oe, 2'b01);
    chk("R9 standby off", standby, 1'b0);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_addr();
    t_abort();
    t_extra();
    t_alg();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule